// File: doc/BRIEF.md
# Crosspoint Matrix Write Sequencer

This block sits on the host side of an 8-column by 12-row analog crosspoint switch matrix and drives the matrix's control port. Commands come in on a single-entry valid/ready handshake. A command either sets one crosspoint on or off, or clears the whole matrix. The block turns each command into the level-timed pin activity the matrix expects: a 7-bit switch address, a data level, an active-high strobe pulse and an active-high master clear pulse.

All timing is counted in clock cycles. Each minimum is given in nanoseconds and turned into a cycle count by rounding up against the clock period. The minimums cover address and data setup before the strobe rises, strobe width, address and data hold after the strobe falls, clear pulse width, and the shortest allowed interval between strobe pulses (no faster than 10 MHz). A set command that names a row the matrix does not have is refused with a one-cycle error pulse. It produces no strobe.

Top module: `xpt_write_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `cmd_ready` is 1 and `xp_strobe`, `xp_clear`, `cmd_err`, `xp_addr` and `xp_data` are all 0.
- R2: A set command accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1 drives `xp_addr = {cmd_row, cmd_col}` (row in bits 6:3, column in bits 2:0) and `xp_data = cmd_on` from that edge onward, and produces exactly one strobe pulse.
- R3: `xp_strobe` rises no sooner than ceil(SETUP_NS / CLK_PERIOD_NS) cycles after `xp_addr`/`xp_data` last changed. When the interval limit does not apply, it rises exactly that many cycles after acceptance.
- R4: Each strobe pulse is high for exactly ceil(PULSE_NS / CLK_PERIOD_NS) cycles.
- R5: After the strobe falls, `xp_addr` and `xp_data` stay unchanged and `cmd_ready` returns high exactly ceil(HOLD_NS / CLK_PERIOD_NS) cycles later.
- R6: Rising edges of `xp_strobe` are at least ceil(MIN_CYCLE_NS / CLK_PERIOD_NS) cycles apart. If needed, the setup phase is stretched to meet this.
- R7: A clear command (`cmd_clear` = 1, row, column and on/off ignored) raises `xp_clear` for exactly ceil(CLEAR_NS / CLK_PERIOD_NS) cycles, with `xp_strobe` low and `xp_addr` unchanged. `cmd_ready` then returns high ceil(HOLD_NS / CLK_PERIOD_NS) cycles after `xp_clear` falls.
- R8: A set command with `cmd_row` greater than 11 is accepted, raises `cmd_err` for one cycle in the cycle after acceptance, leaves `xp_addr`/`xp_data` unchanged, produces no strobe, and leaves `cmd_ready` high.
- R9: `cmd_ready` is low from acceptance of a set or clear command until its hold or recovery phase ends. `xp_strobe` and `xp_clear` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken on this edge if valid |
| cmd_clear | input | 1 | 1 = clear whole matrix, 0 = set one crosspoint |
| cmd_row | input | 4 | Row index (0 to 11 valid) |
| cmd_col | input | 3 | Column index |
| cmd_on | input | 1 | 1 = switch on, 0 = switch off |
| cmd_err | output | 1 | One-cycle pulse: set command refused for a bad row |
| xp_addr | output | 7 | Switch address to the matrix, {row, column} |
| xp_data | output | 1 | Data level to the matrix |
| xp_strobe | output | 1 | Write strobe, active high |
| xp_clear | output | 1 | Master clear, active high |

## Verification
On every cycle, the embedded assertions check the timing envelope of the output pins. They check that the strobe rises only after the address and data have settled long enough, that strobe and clear widths match their counts, that the address holds still while the strobe is high or just falling, that strobe rises are spaced far enough apart, that strobe and clear never overlap, and that a refused command leaves the pins quiet. Only the bench scenarios can show the mapping from each command to the right address and data, the ordering of pulses against the commands issued, the exact setup count after an idle stretch, the exact return of ready after hold or recovery, and that a clear ignores its row field even when that row is out of range.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_CLEAR,
    ST_RECOVER
  } seq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/xpt_phase_timer.sv
module xpt_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/xpt_rate_gate.sv
module xpt_rate_gate #(
  parameter int PERIOD_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic ok
);
  localparam int W = $clog2(PERIOD_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(PERIOD_CYC - 1);

  logic [W-1:0] since;

  // Counts cycles since the last strobe rise, saturating at the limit.
  always_ff @(posedge clk) begin
    if (rst)            since <= LIMIT;
    else if (fire)      since <= '0;
    else if (!ok)       since <= since + 1'b1;
  end

  assign ok = (since >= LIMIT);
endmodule

// File: rtl/xpt_addr_map.sv
module xpt_addr_map #(
  parameter int ROW_W     = 4,
  parameter int COL_W     = 3,
  parameter int ROW_COUNT = 12
) (
  input  logic [ROW_W-1:0]       row,
  input  logic [COL_W-1:0]       col,
  output logic                   row_ok,
  output logic [ROW_W+COL_W-1:0] addr
);
  assign addr = {row, col};

  generate
    if (ROW_COUNT >= (1 << ROW_W)) begin : g_full
      assign row_ok = 1'b1;
    end else begin : g_partial
      assign row_ok = (row < ROW_W'(ROW_COUNT));
    end
  endgenerate
endmodule

// File: rtl/xpt_write_seq.sv
module xpt_write_seq #(
  parameter int CLK_PERIOD_NS = 4,
  parameter int SETUP_NS      = 20,
  parameter int PULSE_NS      = 40,
  parameter int HOLD_NS       = 20,
  parameter int CLEAR_NS      = 80,
  parameter int MIN_CYCLE_NS  = 100,
  parameter int ROW_W         = 4,
  parameter int COL_W         = 3,
  parameter int ROW_COUNT     = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_clear,
  input  logic [ROW_W-1:0]       cmd_row,
  input  logic [COL_W-1:0]       cmd_col,
  input  logic                   cmd_on,
  output logic                   cmd_err,
  output logic [ROW_W+COL_W-1:0] xp_addr,
  output logic                   xp_data,
  output logic                   xp_strobe,
  output logic                   xp_clear
);
  import xpt_pkg::*;

  localparam int SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC  = ns_to_cyc(PULSE_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int CLEAR_CYC  = ns_to_cyc(CLEAR_NS, CLK_PERIOD_NS);
  localparam int PERIOD_CYC = ns_to_cyc(MIN_CYCLE_NS, CLK_PERIOD_NS);
  localparam int ADDR_W     = ROW_W + COL_W;
  localparam int MAX_CYC    = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, CLEAR_CYC));
  localparam int TMR_W      = $clog2(MAX_CYC + 1);

  seq_state_e        state, nxt;
  logic              accept;
  logic              row_ok;
  logic [ADDR_W-1:0] map_addr;
  logic              tmr_load, tmr_done;
  logic [TMR_W-1:0]  tmr_val;
  logic              gap_ok, strobe_fire;

  xpt_addr_map #(.ROW_W(ROW_W), .COL_W(COL_W), .ROW_COUNT(ROW_COUNT)) u_map (
    .row(cmd_row), .col(cmd_col), .row_ok(row_ok), .addr(map_addr)
  );

  xpt_phase_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  xpt_rate_gate #(.PERIOD_CYC(PERIOD_CYC)) u_gate (
    .clk(clk), .rst(rst), .fire(strobe_fire), .ok(gap_ok)
  );

  assign cmd_ready   = (state == ST_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign strobe_fire = (state == ST_SETUP) && (nxt == ST_STROBE);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        if (cmd_clear) begin
          nxt = ST_CLEAR;   tmr_load = 1'b1; tmr_val = TMR_W'(CLEAR_CYC - 1);
        end else if (row_ok) begin
          nxt = ST_SETUP;   tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: if (tmr_done && gap_ok) begin
        nxt = ST_STROBE;    tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1);
      end
      ST_STROBE: if (tmr_done) begin
        nxt = ST_HOLD;      tmr_load = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
      end
      ST_HOLD: if (tmr_done) nxt = ST_IDLE;
      ST_CLEAR: if (tmr_done) begin
        nxt = ST_RECOVER;   tmr_load = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
      end
      ST_RECOVER: if (tmr_done) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      xp_addr   <= '0;
      xp_data   <= 1'b0;
      xp_strobe <= 1'b0;
      xp_clear  <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      state     <= nxt;
      xp_strobe <= (nxt == ST_STROBE);
      xp_clear  <= (nxt == ST_CLEAR);
      cmd_err   <= accept && !cmd_clear && !row_ok;
      if (accept && !cmd_clear && row_ok) begin
        xp_addr <= map_addr;
        xp_data <= cmd_on;
      end
    end
  end

  // ---------------- embedded checks ----------------
  logic [ADDR_W-1:0] prev_addr;
  logic              prev_data;
  logic [15:0]       settle_age, hi_run, clr_run, rise_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_addr  <= '0;
      prev_data  <= 1'b0;
      settle_age <= 16'd1;
      hi_run     <= '0;
      clr_run    <= '0;
      rise_gap   <= 16'(PERIOD_CYC);
    end else begin
      prev_addr  <= xp_addr;
      prev_data  <= xp_data;
      if (xp_addr != prev_addr || xp_data != prev_data) settle_age <= 16'd1;
      else if (settle_age != 16'hFFFF)                  settle_age <= settle_age + 16'd1;
      hi_run  <= xp_strobe ? hi_run + 16'd1 : 16'd0;
      clr_run <= xp_clear ? clr_run + 16'd1 : 16'd0;
      if (xp_strobe && hi_run == 16'd0)  rise_gap <= 16'd1;
      else if (rise_gap != 16'hFFFF)     rise_gap <= rise_gap + 16'd1;
    end
  end

  assert_setup_time_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(xp_strobe) |-> (settle_age >= 16'(SETUP_CYC)));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(xp_strobe) |-> (hi_run == 16'(PULSE_CYC)));

  assert_addr_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (xp_strobe || $fell(xp_strobe)) |-> ($stable(xp_addr) && $stable(xp_data)));

  assert_strobe_rate_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(xp_strobe) |-> (rise_gap >= 16'(PERIOD_CYC)));

  assert_clear_width_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(xp_clear) |-> (clr_run == 16'(CLEAR_CYC)));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> (!xp_strobe && !xp_clear && $stable(xp_addr) && cmd_ready));

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(xp_strobe && xp_clear));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (xp_strobe || xp_clear) |-> !cmd_ready);

endmodule

// File: tb/xpt_write_seq_bench.sv
`timescale 1ns/1ps
module xpt_write_seq_bench;
  // R3 R4 R5 R6 R7: cycle counts from ceiling of ns over a 4 ns period
  localparam int PER   = 4;
  localparam int S_CYC = (20  + PER - 1) / PER;
  localparam int P_CYC = (40  + PER - 1) / PER;
  localparam int H_CYC = (20  + PER - 1) / PER;
  localparam int C_CYC = (80  + PER - 1) / PER;
  localparam int G_CYC = (100 + PER - 1) / PER;

  typedef struct {
    int         kind;   // 0 set, 1 clear, 2 refused
    logic [6:0] addr;
    logic       data;
    bit         exact;
  } item_t;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_clear = 1'b0, cmd_on = 1'b0;
  logic [3:0] cmd_row = '0;
  logic [2:0] cmd_col = '0;
  logic cmd_ready, cmd_err, xp_data, xp_strobe, xp_clear;
  logic [6:0] xp_addr;

  int tests = 0, fails = 0;
  bit finished = 0;
  item_t exp_q[$];
  logic [6:0] model_addr = '0;
  logic       model_data = 1'b0;

  always #2 clk = ~clk;

  xpt_write_seq u_xpt_write_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_clear(cmd_clear), .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_on(cmd_on),
    .cmd_err(cmd_err), .xp_addr(xp_addr), .xp_data(xp_data),
    .xp_strobe(xp_strobe), .xp_clear(xp_clear)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: push the expected item, then hold valid until the handshake completes.
  task automatic send(input bit clr, input int row, input int col, input bit on,
                      input bit exact);
    item_t it;
    if (clr) begin
      it.kind = 1;
    end else if (row > 11) begin
      it.kind = 2;
    end else begin
      it.kind = 0;
      model_addr = {4'(row), 3'(col)};
      model_data = on;
    end
    it.addr = model_addr; it.data = model_data; it.exact = exact;
    exp_q.push_back(it);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_clear = clr; cmd_row = 4'(row); cmd_col = 3'(col); cmd_on = on;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_clear = 1'b0;
  endtask

  // Monitor / scoreboard
  logic       p_strobe = 0, p_clear = 0;
  logic [6:0] p_addr = '0;
  logic       p_data = 0;
  int cyc = 0, age = 0, hi = 0, chi = 0, post = 0, last_rise = -1000;
  bit wait_rdy = 0, mon_on = 0;
  item_t cur;

  function automatic bit pop(output item_t it);
    if (exp_q.size() == 0) return 0;
    it = exp_q.pop_front();
    return 1;
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (xp_addr != p_addr || xp_data != p_data) age = 0; else age++;
      if (wait_rdy) begin
        post++;
        if (cmd_ready) begin
          check(post == H_CYC, "R5", "ready return after hold/recovery", post, H_CYC);
          wait_rdy = 0;
        end
        if (age == 0) check(0, "R5", "address moved during hold", xp_addr, p_addr);
      end
      if (xp_strobe && !p_strobe) begin
        if (!pop(cur)) check(0, "R2", "unexpected strobe", 1, 0);
        else begin
          check(cur.kind == 0, "R2", "strobe for item kind", cur.kind, 0);
          check(xp_addr == cur.addr, "R2", "address at strobe", xp_addr, cur.addr);
          check(xp_data == cur.data, "R2", "data at strobe", xp_data, cur.data);
          if (cur.exact) check(age == S_CYC, "R3", "exact setup cycles", age, S_CYC);
          else           check(age >= S_CYC, "R3", "minimum setup cycles", age, S_CYC);
        end
        check(cyc - last_rise >= G_CYC, "R6", "strobe interval", cyc - last_rise, G_CYC);
        last_rise = cyc;
        hi = 1;
      end else if (xp_strobe) hi++;
      if (!xp_strobe && p_strobe) begin
        check(hi == P_CYC, "R4", "strobe width", hi, P_CYC);
        post = 0; wait_rdy = 1;
      end
      if (xp_clear && !p_clear) begin
        if (!pop(cur)) check(0, "R7", "unexpected clear", 1, 0);
        else begin
          check(cur.kind == 1, "R7", "clear for item kind", cur.kind, 1);
          check(xp_addr == cur.addr, "R7", "address kept on clear", xp_addr, cur.addr);
        end
        chi = 1;
      end else if (xp_clear) chi++;
      if (xp_clear) check(!xp_strobe, "R7", "strobe during clear", xp_strobe, 0);
      if (!xp_clear && p_clear) begin
        check(chi == C_CYC, "R7", "clear width", chi, C_CYC);
        post = 0; wait_rdy = 1;
      end
      if ((xp_strobe || xp_clear) && cmd_ready)
        check(0, "R9", "ready high while busy", cmd_ready, 0);
      if (cmd_err) begin
        if (!pop(cur)) check(0, "R8", "unexpected error", 1, 0);
        else begin
          check(cur.kind == 2, "R8", "error for item kind", cur.kind, 2);
          check(xp_addr == cur.addr && xp_data == cur.data, "R8", "pins kept on refusal",
                xp_addr, cur.addr);
          check(cmd_ready && !xp_strobe, "R8", "ready high and no strobe", cmd_ready, 1);
        end
      end
    end
    p_strobe = xp_strobe; p_clear = xp_clear; p_addr = xp_addr; p_data = xp_data;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_ready == 1 && xp_strobe == 0 && xp_clear == 0 && cmd_err == 0,
          "R1", "control outputs in reset", {cmd_ready, xp_strobe, xp_clear, cmd_err}, 8);
    check(xp_addr == 0 && xp_data == 0, "R1", "address/data in reset", xp_addr, 0);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_ready == 1 && xp_strobe == 0 && xp_addr == 0, "R1", "state after reset",
          cmd_ready, 1);
    mon_on = 1;
    send(0, 3, 5, 1, 1);            // R2 R3 fresh write
    send(0, 11, 7, 0, 0);           // boundary row, back-to-back: R6 stretch
    send(0, 0, 0, 1, 0);
    send(0, 12, 2, 1, 0);           // R8 refused
    send(0, 15, 7, 0, 0);           // R8 refused
    send(1, 15, 3, 1, 0);           // R7 clear ignores row
    send(0, 6, 1, 1, 0);
    repeat (40) @(negedge clk);
    send(0, 9, 4, 0, 1);            // R3 exact after idle
    send(1, 0, 0, 0, 0);
    send(0, 1, 6, 1, 0);
    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
    check(cmd_ready == 1, "R9", "idle at end", cmd_ready, 1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R9 watchdog expired: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule